// File: doc/BRIEF.md
# Vector Pack and Shuffle Unit

This block rearranges the elements of wide data vectors. It is fed one or two source vectors, an element width of one, two or four bytes, an operation code and a byte amount. It returns either one result vector or a pair of result vectors. The operations fall into three groups. Pack operations gather the even or odd elements of the sources so that they lie next to each other. Shuffle operations interleave the even or odd elements of the two sources. The single-source operations are deal, interleave and byte rotate. A two-source align splices the sources at a byte offset.

The permutation is combinational. One register stage follows it, so a result appears one clock after its input is accepted and stays on the outputs until the next accepted input replaces it. There is no backpressure: each cycle with `in_vld` high produces exactly one result cycle on `out_vld`.

Top module: `vec_permute_unit`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and both `out_lo` and `out_hi` are all zeros.
- R2: `out_vld` is high in the cycle after each cycle in which `in_vld` was high, and low otherwise. Each accepted input produces exactly one result.
- R3: When `in_vld` is low, the input buses have no effect. `out_lo` and `out_hi` keep the last result.
- R4: Element width codes for `in_sz`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Element k of a 1024-bit vector occupies bytes k*W to k*W+W-1, where W is the width and N = 128/W elements. Op 0 (even pack): output elements 0..N/2-1 are `in_a` elements 0,2,4,…, and elements N/2..N-1 are `in_b` elements 0,2,4,…. Op 1 (odd pack) does the same with elements 1,3,5,….
- R5: Op 2 (deal) uses only `in_a`. The even elements of `in_a` fill the lower half of the output in order, and the odd elements fill the upper half.
- R6: Op 3 (even shuffle): output element 2k is `in_a` element 2k, and element 2k+1 is `in_b` element 2k. Op 4 (odd shuffle): output element 2k is `in_a` element 2k+1, and element 2k+1 is `in_b` element 2k+1.
- R7: Op 5 (paired shuffle) puts the even-shuffle result of R6 on `out_lo` and the odd-shuffle result on `out_hi`.
- R8: Op 6 (interleave) uses only `in_a`. Output element 2k is `in_a` element k, and element 2k+1 is `in_a` element k+N/2.
- R9: Op 7 (rotate): output byte j is `in_a` byte (j + `in_amt`) mod 128. An amount of 0 returns `in_a` unchanged.
- R10: Op 8 (align): output byte j is `in_a` byte j+`in_amt` when that index is below 128. Otherwise it is `in_b` byte j+`in_amt`-128. An amount of 0 returns `in_a`.
- R11: Width code 3 acts exactly like code 0 (one-byte elements).
- R12: Every operation except op 5 drives `out_hi` to zero. Op codes 9 to 15 drive both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input accepted in this cycle |
| in_op | input | 4 | Operation code (R4 to R12) |
| in_sz | input | 2 | Element width code |
| in_amt | input | 7 | Byte amount for rotate and align |
| in_a | input | 1024 | First source vector, byte 0 in bits 7:0 |
| in_b | input | 1024 | Second source vector |
| out_vld | output | 1 | Result valid |
| out_lo | output | 1024 | Result vector, or low half of a pair |
| out_hi | output | 1024 | High half of a pair, otherwise zero |

## Verification
With only one register stage, any fault shows on the very next `out_vld` cycle. A wrong width select shows up as bytes swapped within an element group. A wrong half boundary moves whole elements between the low and high halves of the output. A faulty rotate stage displaces bytes by one power-of-two distance. A result register that loads without `in_vld` shows up on the first idle cycle, when `out_lo` stops matching the last accepted result.

// File: rtl/vp_pkg.sv
package vp_pkg;

    typedef enum logic [3:0] {
        OP_PACK_EVEN = 4'd0,
        OP_PACK_ODD  = 4'd1,
        OP_DEAL      = 4'd2,
        OP_SHUF_EVEN = 4'd3,
        OP_SHUF_ODD  = 4'd4,
        OP_SHUF_PAIR = 4'd5,
        OP_ILV       = 4'd6,
        OP_ROT       = 4'd7,
        OP_ALIGN     = 4'd8
    } vp_op_e;

    localparam int NUM_SIZES = 3;

    // width code -> network index (log2 of element bytes); code 3 aliases 1 byte
    function automatic logic [1:0] size_index(input logic [1:0] code);
        case (code)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/vp_elem_perm.sv
module vp_elem_perm #(
    parameter int VEC_BYTES  = 128,
    parameter int ELEM_BYTES = 1,
    localparam int VBITS     = VEC_BYTES * 8
) (
    input  logic [VBITS-1:0] src_a,
    input  logic [VBITS-1:0] src_b,
    output logic [VBITS-1:0] pk_even,
    output logic [VBITS-1:0] pk_odd,
    output logic [VBITS-1:0] deal,
    output logic [VBITS-1:0] sh_even,
    output logic [VBITS-1:0] sh_odd,
    output logic [VBITS-1:0] ilv
);
    localparam int EW = ELEM_BYTES * 8;
    localparam int NE = VEC_BYTES / ELEM_BYTES;
    localparam int HE = NE / 2;

    logic [NE-1:0][EW-1:0] ae, be;
    logic [NE-1:0][EW-1:0] pe, po, dl, se, so, il;

    assign ae = src_a;
    assign be = src_b;

    for (genvar k = 0; k < HE; k++) begin : g_el
        // gathers: first source fills the lower half
        assign pe[k]      = ae[2*k];
        assign pe[k+HE]   = be[2*k];
        assign po[k]      = ae[2*k+1];
        assign po[k+HE]   = be[2*k+1];
        assign dl[k]      = ae[2*k];
        assign dl[k+HE]   = ae[2*k+1];
        // interleaves: first source on even slots
        assign se[2*k]    = ae[2*k];
        assign se[2*k+1]  = be[2*k];
        assign so[2*k]    = ae[2*k+1];
        assign so[2*k+1]  = be[2*k+1];
        assign il[2*k]    = ae[k];
        assign il[2*k+1]  = ae[k+HE];
    end

    assign pk_even = pe;
    assign pk_odd  = po;
    assign deal    = dl;
    assign sh_even = se;
    assign sh_odd  = so;
    assign ilv     = il;

endmodule

// File: rtl/vp_byte_shift.sv
module vp_byte_shift #(
    parameter int VEC_BYTES = 128,
    localparam int VBITS    = VEC_BYTES * 8,
    localparam int AW       = $clog2(VEC_BYTES)
) (
    input  logic [VBITS-1:0] src_a,
    input  logic [VBITS-1:0] src_b,
    input  logic [AW-1:0]    amt,
    output logic [VBITS-1:0] rot,
    output logic [VBITS-1:0] aln
);
    // log-depth rotators toward byte 0, one per source
    logic [VBITS-1:0] ra [AW+1];
    logic [VBITS-1:0] rb [AW+1];

    assign ra[0] = src_a;
    assign rb[0] = src_b;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 8 * (1 << s);
        assign ra[s+1] = amt[s] ? {ra[s][SH-1:0], ra[s][VBITS-1:SH]} : ra[s];
        assign rb[s+1] = amt[s] ? {rb[s][SH-1:0], rb[s][VBITS-1:SH]} : rb[s];
    end

    assign rot = ra[AW];

    // splice: bytes below the seam come from rotated a, the rest from rotated b
    for (genvar j = 0; j < VEC_BYTES; j++) begin : g_seam
        assign aln[j*8 +: 8] = (32'(amt) + j < VEC_BYTES) ? ra[AW][j*8 +: 8]
                                                          : rb[AW][j*8 +: 8];
    end

endmodule

// File: rtl/vec_permute_unit.sv
module vec_permute_unit #(
    parameter int VEC_BYTES = 128,
    localparam int VBITS    = VEC_BYTES * 8,
    localparam int AW       = $clog2(VEC_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [3:0]       in_op,
    input  logic [1:0]       in_sz,
    input  logic [AW-1:0]    in_amt,
    input  logic [VBITS-1:0] in_a,
    input  logic [VBITS-1:0] in_b,
    output logic             out_vld,
    output logic [VBITS-1:0] out_lo,
    output logic [VBITS-1:0] out_hi
);
    import vp_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [VBITS-1:0] lo;
        logic [VBITS-1:0] hi;
    } state_t;

    state_t st_d, st_q;

    logic [VBITS-1:0] pe_g [NUM_SIZES];
    logic [VBITS-1:0] po_g [NUM_SIZES];
    logic [VBITS-1:0] dl_g [NUM_SIZES];
    logic [VBITS-1:0] se_g [NUM_SIZES];
    logic [VBITS-1:0] so_g [NUM_SIZES];
    logic [VBITS-1:0] il_g [NUM_SIZES];
    logic [VBITS-1:0] rot_w, aln_w;
    logic [1:0]       sz_sel;

    // one element network per supported width
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        vp_elem_perm #(
            .VEC_BYTES  (VEC_BYTES),
            .ELEM_BYTES (1 << g)
        ) u_perm (
            .src_a   (in_a),
            .src_b   (in_b),
            .pk_even (pe_g[g]),
            .pk_odd  (po_g[g]),
            .deal    (dl_g[g]),
            .sh_even (se_g[g]),
            .sh_odd  (so_g[g]),
            .ilv     (il_g[g])
        );
    end

    vp_byte_shift #(.VEC_BYTES(VEC_BYTES)) u_shift (
        .src_a (in_a),
        .src_b (in_b),
        .amt   (in_amt),
        .rot   (rot_w),
        .aln   (aln_w)
    );

    assign sz_sel = size_index(in_sz);

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.lo = '0;
            st_d.hi = '0;
            case (vp_op_e'(in_op))
                OP_PACK_EVEN: st_d.lo = pe_g[sz_sel];
                OP_PACK_ODD:  st_d.lo = po_g[sz_sel];
                OP_DEAL:      st_d.lo = dl_g[sz_sel];
                OP_SHUF_EVEN: st_d.lo = se_g[sz_sel];
                OP_SHUF_ODD:  st_d.lo = so_g[sz_sel];
                OP_SHUF_PAIR: begin
                    st_d.lo = se_g[sz_sel];
                    st_d.hi = so_g[sz_sel];
                end
                OP_ILV:       st_d.lo = il_g[sz_sel];
                OP_ROT:       st_d.lo = rot_w;
                OP_ALIGN:     st_d.lo = aln_w;
                default:      st_d.lo = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_lo  = st_q.lo;
    assign out_hi  = st_q.hi;

endmodule

// File: rtl/vp_checker.sv
module vp_checker #(
    parameter int VEC_BYTES = 128,
    localparam int VBITS    = VEC_BYTES * 8,
    localparam int AW       = $clog2(VEC_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [3:0]       in_op,
    input logic [AW-1:0]    in_amt,
    input logic [VBITS-1:0] in_a,
    input logic             out_vld,
    input logic [VBITS-1:0] out_lo,
    input logic [VBITS-1:0] out_hi
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_lo) && $stable(out_hi)));

    a_r12_hi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op != 4'd5) |=> (out_hi == '0));

    a_r9_rotate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == 4'd7 && in_amt == '0) |=> (out_lo == $past(in_a)));

    a_r10_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == 4'd8 && in_amt == '0) |=> (out_lo == $past(in_a)));

endmodule

bind vec_permute_unit vp_checker #(.VEC_BYTES(VEC_BYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_op   (in_op),
    .in_amt  (in_amt),
    .in_a    (in_a),
    .out_vld (out_vld),
    .out_lo  (out_lo),
    .out_hi  (out_hi)
);

// File: tb/sim_vec_permute_unit.sv
`timescale 1ns/1ps
module sim_vec_permute_unit;
    localparam int VB    = 128;
    localparam int VBITS = VB * 8;
    localparam int AW    = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_vld;
    logic [3:0]       in_op;
    logic [1:0]       in_sz;
    logic [AW-1:0]    in_amt;
    logic [VBITS-1:0] in_a, in_b;
    logic             out_vld;
    logic [VBITS-1:0] out_lo, out_hi;

    always #4 clk = ~clk;

    vec_permute_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_sz(in_sz),
        .in_amt(in_amt), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_lo(out_lo), .out_hi(out_hi)
    );

    typedef struct {
        logic [VBITS-1:0] lo;
        logic [VBITS-1:0] hi;
        string            tag;
        int               op;
        int               sz;
    } exp_t;

    exp_t             sb[$];
    exp_t             got;
    int               checks = 0;
    int               bad = 0;
    bit               done = 0;
    logic [VBITS-1:0] last_lo, last_hi;
    int unsigned      seed = 32'h1234_5678;

    function automatic logic [7:0] bt(input logic [VBITS-1:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    // reference model written from the requirement text
    function automatic void model(input int op, input int sz, input int amt,
                                  input logic [VBITS-1:0] a, input logic [VBITS-1:0] b,
                                  output logic [VBITS-1:0] lo, output logic [VBITS-1:0] hi);
        int w;
        int h;
        w  = (sz == 1) ? 2 : (sz == 2) ? 4 : 1;
        h  = (VB / w) / 2;
        lo = '0;
        hi = '0;
        for (int j = 0; j < VB; j++) begin
            int e;
            int o;
            logic [7:0] ev, od, v;
            e  = j / w;
            o  = j % w;
            ev = (e % 2 == 0) ? bt(a, e*w + o) : bt(b, (e-1)*w + o);
            od = (e % 2 == 0) ? bt(a, (e+1)*w + o) : bt(b, e*w + o);
            case (op)
                0: v = (e < h) ? bt(a, 2*e*w + o) : bt(b, 2*(e-h)*w + o);
                1: v = (e < h) ? bt(a, (2*e+1)*w + o) : bt(b, (2*(e-h)+1)*w + o);
                2: v = (e < h) ? bt(a, 2*e*w + o) : bt(a, (2*(e-h)+1)*w + o);
                3: v = ev;
                4: v = od;
                5: begin v = ev; hi[j*8 +: 8] = od; end
                6: v = (e % 2 == 0) ? bt(a, (e/2)*w + o) : bt(a, ((e-1)/2 + h)*w + o);
                7: v = bt(a, (j + amt) % VB);
                8: v = (j + amt < VB) ? bt(a, j + amt) : bt(b, j + amt - VB);
                default: v = 8'h00;
            endcase
            lo[j*8 +: 8] = v;
        end
    endfunction

    function automatic string tag_of(input int op, input int sz);
        if (sz == 3) return "R11";
        case (op)
            0, 1:    return "R4";
            2:       return "R5";
            3, 4:    return "R6";
            5:       return "R7";
            6:       return "R8";
            7:       return "R9";
            8:       return "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [VBITS-1:0] rnd_vec();
        logic [VBITS-1:0] v;
        for (int i = 0; i < VBITS / 32; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            v[i*32 +: 32] = seed;
        end
        return v;
    endfunction

    task automatic send(input int op, input int sz, input int amt,
                        input logic [VBITS-1:0] a, input logic [VBITS-1:0] b);
        exp_t x;
        @(negedge clk);
        in_vld = 1'b1;
        in_op  = op[3:0];
        in_sz  = sz[1:0];
        in_amt = amt[AW-1:0];
        in_a   = a;
        in_b   = b;
        model(op, sz, amt % VB, a, b, x.lo, x.hi);
        x.tag = tag_of(op, sz);
        x.op  = op;
        x.sz  = sz;
        sb.push_back(x);
        last_lo = x.lo;
        last_hi = x.hi;
    endtask

    // idle with changing inputs, then confirm the outputs held (R3, R2)
    task automatic idle_and_hold();
        @(negedge clk);
        in_vld = 1'b0;
        in_a   = rnd_vec();
        in_b   = rnd_vec();
        in_op  = 4'd7;
        in_amt = 7'd33;
        repeat (2) @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_lo !== last_lo || out_hi !== last_hi) begin
            bad++;
            $display("FAIL R3 idle hold: vld=%b lo=%h exp %h hi=%h exp %h",
                     out_vld, out_lo, last_lo, out_hi, last_hi);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            checks++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 result without input: vld=%b exp 0", out_vld);
            end else begin
                got = sb.pop_front();
                if (out_lo !== got.lo || out_hi !== got.hi) begin
                    bad++;
                    $display("FAIL %s op=%0d sz=%0d lo=%h exp %h hi=%h exp %h",
                             got.tag, got.op, got.sz, out_lo, got.lo, out_hi, got.hi);
                end
            end
        end
    end

    initial begin
        logic [VBITS-1:0] ra, rb;
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_op  = '0;
        in_sz  = '0;
        in_amt = '0;
        in_a   = '0;
        in_b   = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || out_lo !== '0 || out_hi !== '0) begin
            bad++;
            $display("FAIL R1 reset: vld=%b lo=%h hi=%h exp all zero", out_vld, out_lo, out_hi);
        end
        rst_n = 1'b1;

        // pattern 0: byte ramps so each source byte is unique
        for (int i = 0; i < VB; i++) begin
            ra[i*8 +: 8] = 8'(i);
            rb[i*8 +: 8] = 8'(i) | 8'h80;
        end
        for (int op = 0; op < 11; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                send((op == 10) ? 15 : op, sz, (op * 13 + sz * 5) % VB, ra, rb);
            end
        end
        idle_and_hold();

        // boundary amounts for rotate and align (R9, R10)
        send(7, 0, 0, ra, rb);
        send(7, 0, 127, ra, rb);
        send(7, 2, 1, ra, rb);
        send(8, 0, 0, ra, rb);
        send(8, 1, 127, ra, rb);
        send(8, 0, 64, ra, rb);
        idle_and_hold();

        // pattern 1: pseudo-random data, back-to-back inputs
        for (int op = 0; op < 11; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                send((op == 10) ? 9 : op, sz, (op * 29 + sz * 17 + 3) % VB,
                     rnd_vec(), rnd_vec());
            end
        end
        idle_and_hold();

        // single gaps between inputs (R2)
        send(5, 2, 0, rnd_vec(), rnd_vec());
        idle_and_hold();
        send(0, 1, 0, rnd_vec(), rnd_vec());
        idle_and_hold();

        checks++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 missing results: pending=%0d exp 0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run hung, exp completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule